// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block accepts 32-bit single-precision IEEE 754 words from a simple write port and turns each one into an internal record that downstream arithmetic units read directly. The record carries NaN, infinity and zero flags, the sign, a 10-bit exponent that stays biased, a 24-bit significand with the hidden bit written out in its top position, and guard and sticky bits for later rounding.

Two lanes exist, one per operand. Operand A answers to write address 1 and operand B to write address 2. A lane loads only when a write strobe arrives together with its address. The record is registered, so it appears one clock after the write. A per-lane ready flag then rises and stays high. Subnormal inputs are flushed to zero. The two top exponent bits are cleared so that later stages can use them for underflow and overflow detection.

Top module: `fp_operand_unpack`

## Requirements
- R1: A lane loads only on a clock where wr_en_i is 1 and wr_addr_i equals its address (1 for operand A, lane 0; 2 for operand B, lane 1). Writes to any other address, and address matches with wr_en_i at 0, leave both lanes unchanged.
- R2: The low 8 bits of the internal exponent equal the biased exponent field (word bits 30:23). Exponent bits 9 and 8 are 0.
- R3: The sign equals word bit 31. For an exponent field from 1 to 254, the significand is {1, word bits 22:0} and all three flags are 0.
- R4: An exponent field of 0 sets the zero flag and clears the whole significand, including the hidden bit, whatever the fraction is. The NaN and infinity flags are 0.
- R5: An exponent field of 255 with a zero fraction sets the infinity flag. With a nonzero fraction it sets the NaN flag instead. In both cases the significand is {1, fraction}.
- R6: At most one of the NaN, infinity and zero flags is set in a lane at any time.
- R7: The guard and sticky bits are 0 in every loaded record.
- R8: A lane's ready flag is 0 after reset. It is 1 on the clock after that lane's first qualifying write and stays 1 from then on.
- R9: Without a qualifying write, a lane's record holds its value.
- R10: Reset, an active-low asynchronous input, clears every record field and both ready flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_addr_i | input | ADDR_W (4) | Write address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | IEEE 754 single-precision word |
| op_nan_o | output | NUM_OPS (2) | NaN flag per lane |
| op_inf_o | output | NUM_OPS (2) | Infinity flag per lane |
| op_zero_o | output | NUM_OPS (2) | Zero flag per lane |
| op_sign_o | output | NUM_OPS (2) | Sign per lane |
| op_exp_o | output | NUM_OPS*10 | Widened biased exponent; lane n at [n*10 +: 10] |
| op_sig_o | output | NUM_OPS*24 | Significand with explicit hidden bit; lane n at [n*24 +: 24] |
| op_guard_o | output | NUM_OPS (2) | Guard bit per lane |
| op_sticky_o | output | NUM_OPS (2) | Sticky bit per lane |
| op_ready_o | output | NUM_OPS (2) | Record-valid flag per lane |

## Verification
The input words cover every class the unpacker distinguishes:
- ordinary normals of both signs, plus the smallest and largest normal, which check that the exponent passes through unchanged and the hidden bit is inserted;
- positive and negative zeros, and subnormals of either sign, which must flush to a zero significand;
- infinities of both signs;
- NaNs with a fraction in the high bit or only in the lowest bit, which separates NaN from infinity on a single fraction bit.

Vectors alternate between the two lanes, and after each write both lanes are compared, so a load that leaks into the wrong lane shows up. Directed cases cover a matching address with the strobe low, writes to the neighbouring unused addresses, and a reset part-way through the run.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;
  localparam int WORD_W      = 32;
  localparam int EXP_FIELD_W = 8;
  localparam int FRAC_W      = 23;
  localparam int EXP_EXT_W   = 2;
  localparam int EXP_INT_W   = EXP_FIELD_W + EXP_EXT_W;
  localparam int SIG_W       = FRAC_W + 1;

  typedef struct packed {
    logic                 nan;
    logic                 inf;
    logic                 zero;
    logic                 sign;
    logic [EXP_INT_W-1:0] exp;
    logic [SIG_W-1:0]     sig;
    logic                 guard;
    logic                 sticky;
  } frec_t;
endpackage

// File: rtl/fpu_write_decode.sv
module fpu_write_decode #(
  parameter int ADDR_W    = 4,
  parameter int NUM_OPS   = 2,
  parameter int BASE_ADDR = 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  output logic [NUM_OPS-1:0] hit_o
);
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE_ADDR + g);
    assign hit_o[g] = we_i && (addr_i == LANE_ADDR);
  end

  // R1: one address selects at most one lane
  always_comb begin
    a_r1_single_lane: assert ($onehot0(hit_o) || $isunknown(hit_o));
  end
endmodule

// File: rtl/fpu_field_classify.sv
module fpu_field_classify
  import fpu_unpack_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output frec_t             rec_o
);
  logic [EXP_FIELD_W-1:0] efield;
  logic [FRAC_W-1:0]      frac;
  logic                   e_zero, e_max, f_nz;

  assign efield = word_i[WORD_W-2 -: EXP_FIELD_W];
  assign frac   = word_i[FRAC_W-1:0];
  assign e_zero = (efield == '0);
  assign e_max  = &efield;
  assign f_nz   = |frac;

  always_comb begin
    rec_o        = '0;
    rec_o.sign   = word_i[WORD_W-1];
    rec_o.exp    = {{EXP_EXT_W{1'b0}}, efield};
    // subnormals flush: hidden bit and fraction both dropped
    rec_o.sig    = e_zero ? '0 : {1'b1, frac};
    rec_o.zero   = e_zero;
    rec_o.inf    = e_max && !f_nz;
    rec_o.nan    = e_max && f_nz;
    rec_o.guard  = 1'b0;
    rec_o.sticky = 1'b0;
  end
endmodule

// File: rtl/fpu_rec_reg.sv
module fpu_rec_reg
  import fpu_unpack_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  frec_t rec_i,
  output frec_t rec_o,
  output logic  ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_o   <= '0;
      ready_o <= 1'b0;
    end else if (load_i) begin
      rec_o   <= rec_i;
      ready_o <= 1'b1;
    end
  end

  a_r8_ready_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ready_o);
  a_r8_ready_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r9_hold_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(rec_o));
  a_r6_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rec_o.nan, rec_o.inf, rec_o.zero}));
  a_r2_exp_top_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_o.exp[EXP_INT_W-1 -: EXP_EXT_W] == '0);
  a_r7_no_round_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_o.guard && !rec_o.sticky);
  a_r4_zero_flushed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_o.zero |-> (rec_o.sig == '0));
  a_r5_special_exp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_o.nan || rec_o.inf) |-> (&rec_o.exp[EXP_FIELD_W-1:0]));
endmodule

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
  import fpu_unpack_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_OPS   = 2,
  parameter int BASE_ADDR = 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic                           wr_en_i,
  input  logic [WORD_W-1:0]              wr_data_i,
  output logic [NUM_OPS-1:0]             op_nan_o,
  output logic [NUM_OPS-1:0]             op_inf_o,
  output logic [NUM_OPS-1:0]             op_zero_o,
  output logic [NUM_OPS-1:0]             op_sign_o,
  output logic [NUM_OPS*EXP_INT_W-1:0]   op_exp_o,
  output logic [NUM_OPS*SIG_W-1:0]       op_sig_o,
  output logic [NUM_OPS-1:0]             op_guard_o,
  output logic [NUM_OPS-1:0]             op_sticky_o,
  output logic [NUM_OPS-1:0]             op_ready_o
);
  logic [NUM_OPS-1:0] hit;
  frec_t              rec_new;
  frec_t              rec_q [NUM_OPS];

  fpu_write_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_OPS  (NUM_OPS),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .addr_i(wr_addr_i),
    .we_i  (wr_en_i),
    .hit_o (hit)
  );

  // one classifier serves all lanes: only one lane loads per write
  fpu_field_classify u_classify (
    .word_i(wr_data_i),
    .rec_o (rec_new)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fpu_rec_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (hit[g]),
      .rec_i  (rec_new),
      .rec_o  (rec_q[g]),
      .ready_o(op_ready_o[g])
    );
    assign op_nan_o[g]                        = rec_q[g].nan;
    assign op_inf_o[g]                        = rec_q[g].inf;
    assign op_zero_o[g]                       = rec_q[g].zero;
    assign op_sign_o[g]                       = rec_q[g].sign;
    assign op_exp_o[g*EXP_INT_W +: EXP_INT_W] = rec_q[g].exp;
    assign op_sig_o[g*SIG_W +: SIG_W]         = rec_q[g].sig;
    assign op_guard_o[g]                      = rec_q[g].guard;
    assign op_sticky_o[g]                     = rec_q[g].sticky;

    // R10: ready never stands without a loaded record after reset
    a_r10_ready_from_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_ready_o[g] == 1'b0) |-> (rec_q[g] == '0));
  end
endmodule

// File: tb/fp_operand_unpack_bench.sv
module fp_operand_unpack_bench;
  localparam int NV = 12;
  // {word, flags nan/inf/zero, sign, exp8, sig24}
  localparam logic [67:0] VEC [NV] = '{
    {32'h3F800000, 3'b000, 1'b0, 8'h7F, 24'h800000},
    {32'hC0490FDB, 3'b000, 1'b1, 8'h80, 24'hC90FDB},
    {32'h00000000, 3'b001, 1'b0, 8'h00, 24'h000000},
    {32'h80000000, 3'b001, 1'b1, 8'h00, 24'h000000},
    {32'h00400000, 3'b001, 1'b0, 8'h00, 24'h000000},
    {32'h7F800000, 3'b010, 1'b0, 8'hFF, 24'h800000},
    {32'hFF800000, 3'b010, 1'b1, 8'hFF, 24'h800000},
    {32'h7FC00000, 3'b100, 1'b0, 8'hFF, 24'hC00000},
    {32'h7F800001, 3'b100, 1'b0, 8'hFF, 24'h800001},
    {32'h00800000, 3'b000, 1'b0, 8'h01, 24'h800000},
    {32'h7F7FFFFF, 3'b000, 1'b0, 8'hFE, 24'hFFFFFF},
    {32'h807FFFFF, 3'b001, 1'b1, 8'h00, 24'h000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  nan_o, inf_o, zero_o, sign_o, guard_o, sticky_o, ready_o;
  logic [19:0] exp_o;
  logic [47:0] sig_o;

  int errors = 0;
  int checks = 0;
  logic [39:0] shadow [2];

  always #2 clk = ~clk;

  fp_operand_unpack u_fp_operand_unpack (
    .clk_i(clk), .rst_ni(rst_n), .wr_addr_i(wr_addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .op_nan_o(nan_o), .op_inf_o(inf_o), .op_zero_o(zero_o),
    .op_sign_o(sign_o), .op_exp_o(exp_o), .op_sig_o(sig_o), .op_guard_o(guard_o),
    .op_sticky_o(sticky_o), .op_ready_o(ready_o)
  );

  function automatic logic [39:0] lane_rec(int l);
    return {nan_o[l], inf_o[l], zero_o[l], sign_o[l], exp_o[l*10 +: 10],
            sig_o[l*24 +: 24], guard_o[l], sticky_o[l]};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic we, logic [31:0] d);
    @(negedge clk);
    wr_addr = a; wr_en = we; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_both(string req);
    check(req, "lane0 record", 64'(lane_rec(0)), 64'(shadow[0]));
    check(req, "lane1 record", 64'(lane_rec(1)), 64'(shadow[1]));
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    shadow[0] = '0; shadow[1] = '0;
    repeat (3) @(negedge clk);
    check("R10", "reset records", 64'({lane_rec(0), lane_rec(1)} != '0), 64'(0));
    check("R8", "ready after reset", 64'(ready_o), 64'(2'b00));
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] w;
      logic [2:0]  fl;
      logic        s;
      logic [7:0]  e;
      logic [23:0] m;
      int          lane;
      string       tag;
      {w, fl, s, e, m} = VEC[i];
      lane = i % 2;
      bus_write(4'(lane + 1), 1'b1, w);
      // R2 R6 R7 covered by the full-record compare; other lane checks R9
      shadow[lane] = {fl, s, 2'b00, e, m, 2'b00};
      tag = fl[0] ? "R4" : ((fl[1] || fl[2]) ? "R5" : "R3");
      check_both(tag);
      if (i == 0) check("R8", "ready after first A write", 64'(ready_o), 64'(2'b01));
    end
    check("R8", "ready held after loads", 64'(ready_o), 64'(2'b11));

    // R1: address match with strobe low
    bus_write(4'd1, 1'b0, 32'h40000000);
    check_both("R1");
    // R1: neighbouring addresses ignored
    bus_write(4'd0, 1'b1, 32'h40000000);
    check_both("R1");
    bus_write(4'd3, 1'b1, 32'hBF800000);
    check_both("R1");
    // R9: idle cycles
    repeat (4) @(negedge clk);
    check_both("R9");
    check("R8", "ready sticks", 64'(ready_o), 64'(2'b11));
    // R7 guard/sticky explicit
    check("R7", "guard/sticky", 64'({guard_o, sticky_o}), 64'(0));

    // R10 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R10", "async reset records", 64'({lane_rec(0), lane_rec(1)} != '0), 64'(0));
    check("R10", "async reset ready", 64'(ready_o), 64'(2'b00));
    @(negedge clk); rst_n = 1'b1;
    bus_write(4'd2, 1'b1, 32'h3F800000);
    check("R8", "ready B only after reset", 64'(ready_o), 64'(2'b10));
    check("R3", "lane1 after reset", 64'(lane_rec(1)),
          64'({3'b000, 1'b0, 2'b00, 8'h7F, 24'h800000, 2'b00}));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule